// File: doc/BRIEF.md
# Debug Event Qualifier

This block takes the per-entry address-hit flags of a bank of hardware breakpoints or watchpoints and decides which of them really raise a debug event. An address match is only a precondition. Each entry's 32-bit control word then qualifies the hit against three things: the current privilege level (0 to 3), the current security state and, optionally, one linked context breakpoint. That linked breakpoint is chosen by an index in the control word, and it compares the current context ID with its value word.

All entries are evaluated in parallel. The block registers a per-entry match vector, an aggregate event flag, and the fault-status code that the event should report. The fault-status code depends on whether the long-descriptor translation format is active. A global monitor-debug enable and a debug-exception mask can suppress every event. Address comparison, byte-lane masking and exception delivery are done elsewhere.

Top module: `dbgm_match_top`

## Requirements
- R1: When `mon_dbg_en` is 0 or `dbg_masked` is 1, no entry matches and `evt_o` is 0 one cycle later.
- R2: An entry whose `entry_hit` bit is 0 never matches.
- R3: Control bits 15:14 select security qualification. 2'b00 matches in either state. 2'b01 and 2'b11 match only when `cur_secure` is 0. 2'b10 matches only when `cur_secure` is 1.
- R4: At levels 2 and 3 a match needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R5: An entry whose `entry_unpriv` bit is 1 is qualified as if the current level were 0.
- R6: When control bit 20 is 1, the linked breakpoint at the index in control bits 19:16 must also match, and that breakpoint fails when bit 0 of its control word is 0. When bit 20 is 0, the linked breakpoint is ignored.
- R7: A linked breakpoint matches only when bits 23:20 of its control word equal 3, the current level is 0 or 1, and `ctx_id` equals its value word.
- R8: A link index greater than NUM_BRP-1 or less than NUM_BRP-NUM_CTX makes the link fail.
- R9: `evt_vec_o[i]` is the qualified match of entry i, and `evt_o` is the OR of all entries. Both appear one clock after the inputs.
- R10: When `evt_o` is 1, `fault_status_o` is 0x222 if `long_desc` was 1 and 0x002 otherwise. When `evt_o` is 0, it is 0.
- R11: A synchronous reset clears `evt_o`, `evt_vec_o` and `fault_status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_dbg_en | input | 1 | Global monitor-debug enable |
| dbg_masked | input | 1 | Debug exceptions currently masked |
| cur_level | input | 2 | Current privilege level 0..3 |
| cur_secure | input | 1 | Current security state, 1 = secure |
| long_desc | input | 1 | Long-descriptor translation format active |
| ctx_id | input | 32 | Current context ID |
| entry_hit | input | NUM_ENTRIES | Per-entry address-match flags |
| entry_unpriv | input | NUM_ENTRIES | Per-entry unprivileged-access flag |
| entry_ctrl | input | NUM_ENTRIES*32 | Per-entry control words, entry i at bits [32*i +: 32] |
| link_ctrl | input | NUM_BRP*32 | Breakpoint control words indexed by link number |
| link_val | input | NUM_BRP*32 | Low 32 bits of breakpoint value words |
| evt_o | output | 1 | Any entry raised a debug event |
| evt_vec_o | output | NUM_ENTRIES | Per-entry qualified match |
| fault_status_o | output | FSR_W | Fault-status code for the event |

## Verification
A wrong decode of a qualifier field shows up as a bit of `evt_vec_o` that is set or cleared wrongly, exactly one clock after the inputs are applied. Nothing is held across cycles apart from the output registers, so each fault is visible in the cycle right after its stimulus and can be traced to one field value. A stale or mis-selected linked breakpoint shows at the ports only when the link bit is set, so the link index bounds, the type code, the enable bit and the level limit are each driven on their own. A fault-status error appears together with the event flag in the same cycle.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  localparam int WORD_W = 32;

  // Entry control word layout; the qualifier logic decodes these positions.
  typedef struct packed {
    logic [10:0] rsv_hi;   // 31:21
    logic        lnk;      // 20
    logic [3:0]  lbn;      // 19:16
    logic [1:0]  ssc;      // 15:14
    logic        hmc;      // 13
    logic [9:0]  rsv_mid;  // 12:3
    logic [1:0]  pac;      // 2:1
    logic        rsv_lo;   // 0
  } entry_ctrl_t;

  // Linked breakpoint control word layout.
  typedef struct packed {
    logic [7:0]  rsv_hi;   // 31:24
    logic [3:0]  btype;    // 23:20
    logic [18:0] rsv_mid;  // 19:1
    logic        en;       // 0
  } link_ctrl_t;

  localparam logic [3:0] BTYPE_CTX_LINKED = 4'd3;

  localparam logic [1:0] SSC_ANY     = 2'b00;
  localparam logic [1:0] SSC_SECURE  = 2'b10;

  localparam int FSR_DEBUG_LONG  = 32'h0000_0222;
  localparam int FSR_DEBUG_SHORT = 32'h0000_0002;

endpackage

// File: rtl/dbgm_link_eval.sv
module dbgm_link_eval
  import dbgm_pkg::*;
#(
  parameter int NUM_BRP = 6,
  parameter int NUM_CTX = 3
) (
  input  logic [3:0]                link_idx,
  input  logic [NUM_BRP*WORD_W-1:0] link_ctrl,
  input  logic [NUM_BRP*WORD_W-1:0] link_val,
  input  logic [1:0]                cur_level,
  input  logic [WORD_W-1:0]         ctx_id,
  output logic                      link_ok
);

  localparam logic [3:0] IDX_HI = 4'(NUM_BRP - 1);
  localparam logic [3:0] IDX_LO = 4'(NUM_BRP - NUM_CTX);

  link_ctrl_t              sel_ctrl;
  logic [WORD_W-1:0]       sel_val;
  logic                    idx_ok;

  // Explicit compare mux keeps an out-of-range index from reading past the bank.
  always_comb begin
    sel_ctrl = '0;
    sel_val  = '0;
    for (int k = 0; k < NUM_BRP; k++) begin
      if (link_idx == 4'(k)) begin
        sel_ctrl = link_ctrl_t'(link_ctrl[k*WORD_W +: WORD_W]);
        sel_val  = link_val[k*WORD_W +: WORD_W];
      end
    end
  end

  assign idx_ok = (link_idx <= IDX_HI) && (link_idx >= IDX_LO);

  always_comb begin
    link_ok = 1'b0;
    if (idx_ok && sel_ctrl.en) begin
      if (sel_ctrl.btype == BTYPE_CTX_LINKED) begin
        link_ok = !cur_level[1] && (ctx_id == sel_val);
      end
    end
  end

endmodule

// File: rtl/dbgm_entry_qual.sv
module dbgm_entry_qual
  import dbgm_pkg::*;
(
  input  logic              hit,
  input  logic [WORD_W-1:0] ctrl,
  input  logic              unpriv,
  input  logic [1:0]        cur_level,
  input  logic              cur_secure,
  input  logic              link_ok,
  output logic [3:0]        link_idx,
  output logic              match
);

  entry_ctrl_t c;
  logic [1:0]  eff_level;
  logic        sec_ok;
  logic        lvl_ok;
  logic        lnk_pass;

  assign c         = entry_ctrl_t'(ctrl);
  assign link_idx  = c.lbn;
  assign eff_level = unpriv ? 2'd0 : cur_level;

  always_comb begin
    unique case (c.ssc)
      SSC_ANY:    sec_ok = 1'b1;
      SSC_SECURE: sec_ok = cur_secure;
      default:    sec_ok = !cur_secure;
    endcase
  end

  always_comb begin
    unique case (eff_level)
      2'd0:    lvl_ok = c.pac[1];
      2'd1:    lvl_ok = c.pac[0];
      default: lvl_ok = c.hmc;
    endcase
  end

  assign lnk_pass = !c.lnk || link_ok;
  assign match    = hit && sec_ok && lvl_ok && lnk_pass;

endmodule

// File: rtl/dbgm_match_top.sv
module dbgm_match_top
  import dbgm_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_BRP     = 6,
  parameter int NUM_CTX     = 3,
  parameter int FSR_W       = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mon_dbg_en,
  input  logic                          dbg_masked,
  input  logic [1:0]                    cur_level,
  input  logic                          cur_secure,
  input  logic                          long_desc,
  input  logic [WORD_W-1:0]             ctx_id,
  input  logic [NUM_ENTRIES-1:0]        entry_hit,
  input  logic [NUM_ENTRIES-1:0]        entry_unpriv,
  input  logic [NUM_ENTRIES*WORD_W-1:0] entry_ctrl,
  input  logic [NUM_BRP*WORD_W-1:0]     link_ctrl,
  input  logic [NUM_BRP*WORD_W-1:0]     link_val,
  output logic                          evt_o,
  output logic [NUM_ENTRIES-1:0]        evt_vec_o,
  output logic [FSR_W-1:0]              fault_status_o
);

  localparam logic [FSR_W-1:0] FSR_LONG  = FSR_W'(FSR_DEBUG_LONG);
  localparam logic [FSR_W-1:0] FSR_SHORT = FSR_W'(FSR_DEBUG_SHORT);

  logic [NUM_ENTRIES-1:0] raw_match;
  logic [NUM_ENTRIES-1:0] gated_match;
  logic                   dbg_allowed;

  assign dbg_allowed = mon_dbg_en && !dbg_masked;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [3:0] idx;
    logic       lok;

    dbgm_link_eval #(
      .NUM_BRP (NUM_BRP),
      .NUM_CTX (NUM_CTX)
    ) link_i (
      .link_idx  (idx),
      .link_ctrl (link_ctrl),
      .link_val  (link_val),
      .cur_level (cur_level),
      .ctx_id    (ctx_id),
      .link_ok   (lok)
    );

    dbgm_entry_qual qual_i (
      .hit        (entry_hit[i]),
      .ctrl       (entry_ctrl[i*WORD_W +: WORD_W]),
      .unpriv     (entry_unpriv[i]),
      .cur_level  (cur_level),
      .cur_secure (cur_secure),
      .link_ok    (lok),
      .link_idx   (idx),
      .match      (raw_match[i])
    );
  end

  assign gated_match = dbg_allowed ? raw_match : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_vec_o      <= '0;
      evt_o          <= 1'b0;
      fault_status_o <= '0;
    end else begin
      evt_vec_o <= gated_match;
      evt_o     <= |gated_match;
      if (|gated_match) begin
        fault_status_o <= long_desc ? FSR_LONG : FSR_SHORT;
      end else begin
        fault_status_o <= '0;
      end
    end
  end

endmodule

// File: rtl/dbgm_match_chk.sv
module dbgm_match_chk #(
  parameter int NUM_ENTRIES = 4,
  parameter int FSR_W       = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mon_dbg_en,
  input logic                     dbg_masked,
  input logic [1:0]               cur_level,
  input logic                     cur_secure,
  input logic                     long_desc,
  input logic [NUM_ENTRIES-1:0]   entry_hit,
  input logic [NUM_ENTRIES-1:0]   entry_unpriv,
  input logic [31:0]              entry0_ctrl,
  input logic                     evt_o,
  input logic [NUM_ENTRIES-1:0]   evt_vec_o,
  input logic [FSR_W-1:0]         fault_status_o
);

  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_dbg_en || dbg_masked) |=> !evt_o);

  // R2
  no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_hit == '0) |=> (evt_vec_o == '0));

  // R3
  ssc_secure_chk: assert property (@(posedge clk) disable iff (rst)
    (entry0_ctrl[15:14] == 2'b10 && !cur_secure) |=> !evt_vec_o[0]);

  // R4
  high_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_level[1] && !entry0_ctrl[13] && !entry_unpriv[0]) |=> !evt_vec_o[0]);

  // R7
  link_level_chk: assert property (@(posedge clk) disable iff (rst)
    (entry0_ctrl[20] && cur_level[1]) |=> !evt_vec_o[0]);

  // R9
  evt_or_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o == (|evt_vec_o));

  // R10
  fsr_code_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (fault_status_o == ($past(long_desc) ? FSR_W'(12'h222) : FSR_W'(12'h002))));

  // R10
  fsr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_o |-> (fault_status_o == '0));

endmodule

bind dbgm_match_top dbgm_match_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .FSR_W       (FSR_W)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .mon_dbg_en     (mon_dbg_en),
  .dbg_masked     (dbg_masked),
  .cur_level      (cur_level),
  .cur_secure     (cur_secure),
  .long_desc      (long_desc),
  .entry_hit      (entry_hit),
  .entry_unpriv   (entry_unpriv),
  .entry0_ctrl    (entry_ctrl[31:0]),
  .evt_o          (evt_o),
  .evt_vec_o      (evt_vec_o),
  .fault_status_o (fault_status_o)
);

// File: tb/dbgm_match_top_tb.sv
module dbgm_match_top_tb_top;

  localparam int NE  = 4;
  localparam int NB  = 6;
  localparam int FW  = 12;
  localparam logic [31:0] CTX = 32'hCAFE_0004;
  localparam int NVEC = 23;

  // Row: {req[4], exp[1], unpriv[1], secure[1], level[2], ctrl[32]}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd4, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_2006},  // R4 level0 allowed
    {4'd4, 1'b1, 1'b0, 1'b1, 2'd3, 32'h0000_2006},  // R4 level3 with HMC
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_0006},  // R4 level2 no HMC
    {4'd4, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0000_0002},  // R4 level1 bit1
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_0002},  // R4 level0 missing bit2
    {4'd4, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_0004},  // R4 level0 bit2
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_0004},  // R4 level1 missing bit1
    {4'd5, 1'b1, 1'b1, 1'b0, 2'd1, 32'h0000_0004},  // R5 unpriv at level1
    {4'd5, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_2002},  // R5 unpriv at level2
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_A006},  // R3 secure-only, ns
    {4'd3, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_A006},  // R3 secure-only, s
    {4'd3, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000_6006},  // R3 code1, s
    {4'd3, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_6006},  // R3 code1, ns
    {4'd3, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0000_E006},  // R3 code3, s
    {4'd3, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0000_E006},  // R3 code3, ns
    {4'd7, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0014_2006},  // R7 good link
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0014_2006},  // R7 level above 1
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0013_2006},  // R7 wrong type
    {4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0015_2006},  // R6 link disabled
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0012_2006},  // R8 index below range
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0016_2006},  // R8 index above range
    {4'd6, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0004_2006},  // R6 unlinked
    {4'd6, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0006_2006}   // R6 unlinked, bad index
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mon_dbg_en = 1'b1;
  logic              dbg_masked = 1'b0;
  logic [1:0]        cur_level = 2'd0;
  logic              cur_secure = 1'b0;
  logic              long_desc = 1'b0;
  logic [31:0]       ctx_id = CTX;
  logic [NE-1:0]     entry_hit = '0;
  logic [NE-1:0]     entry_unpriv = '0;
  logic [NE*32-1:0]  entry_ctrl = '0;
  logic [NB*32-1:0]  link_ctrl;
  logic [NB*32-1:0]  link_val;
  logic              evt_o;
  logic [NE-1:0]     evt_vec_o;
  logic [FW-1:0]     fault_status_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Indices 0..2 below range, 3 wrong type, 4 good, 5 disabled.
  assign link_ctrl = {32'h0030_0000, 32'h0030_0001, 32'h0050_0001,
                      32'h0030_0001, 32'h0030_0001, 32'h0030_0001};
  assign link_val  = {NB{CTX}};

  always #5 clk = ~clk;

  dbgm_match_top #(.NUM_ENTRIES(NE), .NUM_BRP(NB), .NUM_CTX(3), .FSR_W(FW)) dut_i (
    .clk(clk), .rst(rst), .mon_dbg_en(mon_dbg_en), .dbg_masked(dbg_masked),
    .cur_level(cur_level), .cur_secure(cur_secure), .long_desc(long_desc),
    .ctx_id(ctx_id), .entry_hit(entry_hit), .entry_unpriv(entry_unpriv),
    .entry_ctrl(entry_ctrl), .link_ctrl(link_ctrl), .link_val(link_val),
    .evt_o(evt_o), .evt_vec_o(evt_vec_o), .fault_status_o(fault_status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [NE-1:0] exp_vec, input logic lng);
    logic [31:0] exp_fsr;
    exp_fsr = (exp_vec != '0) ? (lng ? 32'h222 : 32'h002) : 32'h0;
    chk(req, 32'(evt_vec_o), 32'(exp_vec));
    chk(req, 32'(evt_o), 32'(exp_vec != '0));
    chk(req, 32'(fault_status_o), exp_fsr);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state with an active hit pending
    entry_hit = 4'b0001;
    entry_ctrl[31:0] = 32'h0000_2006;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R11", '0, 1'b0);
    rst = 1'b0;
    step();
    check_all("R11", 4'b0001, 1'b0);

    // Table walk, entry 0 only
    entry_hit = 4'b0001;
    for (int v = 0; v < NVEC; v++) begin
      entry_ctrl[31:0] = VEC[v][31:0];
      cur_level        = VEC[v][33:32];
      cur_secure       = VEC[v][34];
      entry_unpriv     = {3'b000, VEC[v][35]};
      step();
      check_all($sformatf("R%0d row %0d", VEC[v][40:37], v), {3'b000, VEC[v][36]}, 1'b0);
    end

    // R7 context mismatch on the good link
    entry_unpriv = '0; cur_secure = 1'b0; cur_level = 2'd1;
    entry_ctrl[31:0] = 32'h0014_2006;
    ctx_id = 32'hCAFE_0005;
    step();
    check_all("R7", 4'b0000, 1'b0);
    ctx_id = CTX;

    // R2 no address hit
    entry_ctrl[31:0] = 32'h0000_2006;
    entry_hit = 4'b0000;
    step();
    check_all("R2", 4'b0000, 1'b0);

    // R1 global enable and mask
    entry_hit = 4'b0001;
    mon_dbg_en = 1'b0;
    step();
    check_all("R1", 4'b0000, 1'b0);
    mon_dbg_en = 1'b1; dbg_masked = 1'b1;
    step();
    check_all("R1", 4'b0000, 1'b0);
    dbg_masked = 1'b0;
    step();
    check_all("R1", 4'b0001, 1'b0);

    // R9 several entries in parallel
    entry_ctrl = {32'h0000_2006, 32'h0000_0000, 32'h0000_2006, 32'h0000_2006};
    entry_hit = 4'b1010;
    step();
    check_all("R9", 4'b1010, 1'b0);
    entry_hit = 4'b1111;
    step();
    check_all("R9", 4'b1011, 1'b0);

    // R10 long-descriptor code
    long_desc = 1'b1;
    step();
    check_all("R10", 4'b1011, 1'b1);
    entry_hit = 4'b0100;
    step();
    check_all("R10", 4'b0000, 1'b1);

    // R11 reset in mid-run
    entry_hit = 4'b1111;
    rst = 1'b1;
    step();
    check_all("R11", 4'b0000, 1'b1);
    rst = 1'b0;
    step();
    check_all("R11", 4'b1011, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule